// File: doc/BRIEF.md
# Half-Divisor Duty-Cycle Correction Stage

This stage sits behind a reload-compare programmable divider and turns its short reload strobe into a divided clock whose high time is half the period. The upstream divider supplies, each input clock cycle, an elapsed-count value and a one-cycle reload strobe that marks the first cycle of each output period. A rising-edge output register is set by the reload strobe. A second compare network watches for the midpoint of the period by matching the elapsed count against the divisor shifted right by one bit, and that match clears the register.

When the divisor is even, the midpoint match clears the output at the next rising input edge, so the high time is exactly half the period. When the divisor is odd, clearing is postponed: a register clocked on the falling input edge cuts the output half an input cycle later than the whole-cycle midpoint, so high and low times differ by no more than what the input clock can resolve. A divisor of one forwards the input clock, and a divisor of zero holds the output low.

Top module: `duty_balance_stage`

## Requirements
- R1: While reset is asserted (rst_ni low), clk_o is 0 for every divisor, including 1.
- R2: For an even divisor N of 2 or more, clk_o rises on the input rising edge that ends the reload cycle and stays high for exactly N/2 input cycles, falling on an input rising edge.
- R3: For an odd divisor N of 3 or more, clk_o stays high for (N-1)/2 input cycles plus one half cycle and falls on an input falling edge.
- R4: For a divisor of 1, clk_o follows clk_i directly.
- R5: For a divisor of 0, clk_o stays low.
- R6: Counter convention: count_i is 0 in the cycle where reload_i is 1 and increases by one each input cycle; the midpoint is the cycle where count_i equals the divisor shifted right by one bit (divisor bits W-1 down to 1).
- R7: A reload takes priority over a pending midpoint: when reload_i is 1 in the same cycle as the midpoint match, clk_o is high after that edge and is not cut during the following cycle.
- R8: Successive rising edges of clk_o are exactly N input cycles apart for every divisor N of 1 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| divisor_i | input | DIV_W | Division ratio N |
| reload_i | input | 1 | One-cycle strobe marking the first cycle of each period |
| count_i | input | DIV_W | Input cycles elapsed since the last reload |
| clk_o | output | 1 | Duty-corrected divided clock |

## Verification
A wrong midpoint compare or a stuck odd-delay register shows up at clk_o within the first output period after the divisor settles, as a high time that differs from N/2 input cycles or a falling edge on the wrong input clock phase. A lost reload priority shows up one cycle after the clashing reload as an early cut of the output. The bench therefore times each high phase and each period of clk_o against the input clock edges for a broad sweep of divisors, including 4, 29, 58, 126, 263 and 511.

// File: rtl/dcc_pkg.sv
`timescale 1ns/1ps
package dcc_pkg;

  localparam int DC_MAX_W = 16;

  typedef enum logic [1:0] {
    DM_OFF  = 2'd0,
    DM_PASS = 2'd1,
    DM_EVEN = 2'd2,
    DM_ODD  = 2'd3
  } dc_mode_e;

  // Operating mode chosen by the divisor value and its lowest bit.
  function automatic dc_mode_e dc_mode_of(input logic [DC_MAX_W-1:0] d);
    if (d == '0)                           return DM_OFF;
    else if (d == {{(DC_MAX_W-1){1'b0}}, 1'b1}) return DM_PASS;
    else if (d[0])                         return DM_ODD;
    else                                   return DM_EVEN;
  endfunction

endpackage

// File: rtl/mid_match_cmp.sv
`timescale 1ns/1ps
module mid_match_cmp #(
  parameter int DIV_W = 9
) (
  input  logic [DIV_W-1:0] count_i,
  input  logic [DIV_W-2:0] half_i,
  output logic             match_o
);
  localparam int CMP_N = DIV_W - 1;

  logic [CMP_N-1:0] bit_eq;

  // One XOR comparison per bit of the halved divisor.
  for (genvar g = 0; g < CMP_N; g++) begin : g_cmp
    assign bit_eq[g] = ~(count_i[g] ^ half_i[g]);
  end

  assign match_o = (&bit_eq) & ~count_i[DIV_W-1];

endmodule

// File: rtl/odd_half_delay.sv
`timescale 1ns/1ps
module odd_half_delay (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic odd_i,
  input  logic reload_i,
  input  logic match_i,
  output logic mid_hit_o,
  output logic cut_o
);
  logic mid_hit_q;
  logic cut_q;

  // Midpoint seen in the previous cycle; a reload withdraws it.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mid_hit_q <= 1'b0;
    else if (reload_i) mid_hit_q <= 1'b0;
    else               mid_hit_q <= odd_i & match_i;
  end

  // Half-cycle later cut, taken on the falling input edge.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cut_q <= 1'b0;
    else         cut_q <= odd_i & mid_hit_q;
  end

  assign mid_hit_o = mid_hit_q;
  assign cut_o     = cut_q;

  // R7: reload clears a pending midpoint
  a_r7_reload_drops_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> !mid_hit_q);

  // R3: a cut appears only after a registered midpoint
  a_r3_cut_follows_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cut_q) |-> mid_hit_q);

endmodule

// File: rtl/out_setclr.sv
`timescale 1ns/1ps
module out_setclr
  import dcc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  dc_mode_e mode_i,
  input  logic     reload_i,
  input  logic     match_i,
  input  logic     mid_hit_i,
  output logic     hi_o
);
  logic hi_q;
  logic duty_clr;

  assign duty_clr = ((mode_i == DM_EVEN) & match_i) |
                    ((mode_i == DM_ODD)  & mid_hit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   hi_q <= 1'b0;
    else if (mode_i == DM_OFF || mode_i == DM_PASS) hi_q <= 1'b0;
    else if (reload_i)                              hi_q <= 1'b1;
    else if (duty_clr)                              hi_q <= 1'b0;
  end

  assign hi_o = hi_q;

  // R2: even midpoint ends the high phase at the next edge
  a_r2_even_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == DM_EVEN && match_i && !reload_i) |=> !hi_q);

  // R7: reload sets the output register
  a_r7_reload_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_i && (mode_i == DM_EVEN || mode_i == DM_ODD)) |=> hi_q);

  // R3: odd midpoint keeps the register high one more cycle
  a_r3_odd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == DM_ODD && match_i && !reload_i && !mid_hit_i && hi_q) |=> hi_q);

  // R5: a zero divisor leaves the register low
  a_r5_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == DM_OFF) |=> !hi_q);

endmodule

// File: rtl/duty_balance_stage.sv
`timescale 1ns/1ps
module duty_balance_stage
  import dcc_pkg::*;
#(
  parameter int DIV_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic             reload_i,
  input  logic [DIV_W-1:0] count_i,
  output logic             clk_o
);
  localparam int PAD_W = DC_MAX_W - DIV_W;

  logic [DC_MAX_W-1:0] div_ext;
  dc_mode_e            mode;
  logic                mid_match;
  logic                mid_hit;
  logic                cut_now;
  logic                out_hi;

  assign div_ext = {{PAD_W{1'b0}}, divisor_i};
  assign mode    = dc_mode_of(div_ext);

  mid_match_cmp #(.DIV_W(DIV_W)) u_cmp (
    .count_i (count_i),
    .half_i  (divisor_i[DIV_W-1:1]),
    .match_o (mid_match)
  );

  odd_half_delay u_odd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .odd_i     (mode == DM_ODD),
    .reload_i  (reload_i),
    .match_i   (mid_match),
    .mid_hit_o (mid_hit),
    .cut_o     (cut_now)
  );

  out_setclr u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .reload_i  (reload_i),
    .match_i   (mid_match),
    .mid_hit_i (mid_hit),
    .hi_o      (out_hi)
  );

  always_comb begin
    case (mode)
      DM_PASS: clk_o = clk_i & rst_ni;
      DM_EVEN: clk_o = out_hi;
      DM_ODD:  clk_o = out_hi & ~cut_now;
      default: clk_o = 1'b0;
    endcase
  end

  // R1: output low in reset
  a_r1_reset_low: assert property (@(posedge clk_i)
    !rst_ni |-> !clk_o);

  // R4: bypass mode shows the input clock high phase
  a_r4_pass_follows: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (mode == DM_PASS) |-> clk_o);

endmodule

// File: tb/sim_duty_balance_stage.sv
`timescale 1ns/1ps
module sim_duty_balance_stage;
  localparam int  W    = 9;
  localparam real TCK  = 5.0;
  localparam real TOL  = 0.01;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] div_b = 9'd1;
  logic [W-1:0] cnt_a = '0;
  logic [W-1:0] cnt_m = '0;
  logic         rl_m = 1'b0;
  logic         man = 1'b0;
  logic         reload_a;
  logic [W-1:0] cnt_in;
  logic         rl_in;
  logic         clk_out;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  // Upstream reload-compare counter model, updated on falling edges.
  always @(negedge clk)
    if (!man)
      cnt_a <= (div_b == 0) ? '0 : ((cnt_a >= div_b - 1) ? '0 : cnt_a + 1);

  assign reload_a = (div_b != 0) && (cnt_a == 0);
  assign cnt_in   = man ? cnt_m : cnt_a;
  assign rl_in    = man ? rl_m  : reload_a;

  duty_balance_stage #(.DIV_W(W)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .divisor_i (div_b),
    .reload_i  (rl_in),
    .count_i   (cnt_in),
    .clk_o     (clk_out)
  );

  task automatic chk(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0.3f expected %0.3f at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit near(input real a, input real b);
    return (a - b < TOL) && (b - a < TOL);
  endfunction

  // Distance of t from the nearest multiple of TCK after offset.
  function automatic real phase_err(input real t, input real off);
    int k;
    k = $rtoi((t - off) / TCK + 0.5);
    return t - off - k * TCK;
  endfunction

  task automatic set_div(input int n);
    @(negedge clk);
    div_b <= n[W-1:0];
  endtask

  task automatic t_reset;
    #3;  chk(clk_out == 1'b0, "R1 reset, N=1, clk high", clk_out, 0);
    #10; chk(clk_out == 1'b0, "R1 reset, N=1, clk high", clk_out, 0);
    div_b = 9'd4;
    #10; chk(clk_out == 1'b0, "R1 reset, N=4", clk_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_measure(input int n);
    real t0, t1, t2;
    set_div(n);
    repeat (2 * n + 4) @(posedge clk);
    @(posedge clk_out); t0 = $realtime;
    @(negedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    // high time is N half-cycles for every divisor (R2 even, R3 odd, R4 for 1)
    if (n == 1)
      chk(near(t1 - t0, 2.5), "R4 high time", t1 - t0, 2.5);
    else if (n % 2 == 0)
      chk(near(t1 - t0, n * 2.5), "R2 R6 high time", t1 - t0, n * 2.5);
    else
      chk(near(t1 - t0, n * 2.5), "R3 R6 high time", t1 - t0, n * 2.5);
    chk(near(t2 - t0, n * TCK), "R8 period", t2 - t0, n * TCK);
    chk(near(phase_err(t0, 2.5), 0.0), "R2 rise on input rising edge", phase_err(t0, 2.5), 0.0);
    if (n >= 3 && n % 2 == 1)
      chk(near(phase_err(t1, 0.0), 0.0), "R3 fall on input falling edge", phase_err(t1, 0.0), 0.0);
    else if (n >= 2)
      chk(near(phase_err(t1, 2.5), 0.0), "R2 fall on input rising edge", phase_err(t1, 2.5), 0.0);
  endtask

  task automatic t_zero;
    set_div(0);
    repeat (4) @(posedge clk);
    for (int i = 0; i < 6; i++) begin
      #1.0; chk(clk_out == 1'b0, "R5 zero divisor high phase", clk_out, 0);
      #2.5; chk(clk_out == 1'b0, "R5 zero divisor low phase", clk_out, 0);
      @(posedge clk);
    end
  endtask

  task automatic t_priority;
    set_div(7);
    repeat (20) @(posedge clk);
    @(negedge clk);
    man  = 1'b1;
    cnt_m = 9'd5; rl_m = 1'b0;
    @(negedge clk);
    cnt_m = 9'd3; rl_m = 1'b1;          // midpoint of 7 together with reload
    @(negedge clk);
    cnt_m = 9'd4; rl_m = 1'b0;
    #1.0; chk(clk_out == 1'b1, "R7 set by reload", clk_out, 1);
    @(negedge clk);
    #1.0; chk(clk_out == 1'b1, "R7 no cut after clashing reload", clk_out, 1);
    cnt_m = 9'd5;
    @(negedge clk);
    man = 1'b0;
  endtask

  initial begin
    t_reset();
    for (int n = 1; n <= 64; n++) t_measure(n);
    for (int n = 65; n <= 511; n += 9) t_measure(n);
    t_measure(126);
    t_measure(263);
    t_measure(511);
    t_measure(256);
    t_measure(255);
    t_zero();
    t_priority();
    t_measure(58);
    t_measure(29);
    t_measure(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(190000 * TCK);
    fails++;
    $display("FAIL watchdog: actual %0t expected end before limit", $time);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule